// File: doc/BRIEF.md
# Translation Stream Fan-In / Fan-Out Switch

This block links several requester-side stream endpoints, such as a group of translation buffers, to one servicing-side endpoint, such as a single translation controller. It has two paths that share no state and run at the same time.

The request path merges `NPORT` stream inputs onto one stream output. A round-robin arbiter picks a source and keeps it for a whole packet. The index of that source goes out on an ID field, so that answers can be sent back to it. The response path reads a destination index from each incoming beat and steers the beat to the matching output. It passes that output's ready back to the source.

No payload is stored anywhere in the block. Every output beat is a combinational copy of an input beat. The only registers are the few bits of arbitration state. Because the request output is itself a plain stream port, it can feed another instance of the switch placed nearer the servicing unit.

Top module: `xlat_stream_switch`

## Requirements
- R1: After reset, with no input valid, no output of either path is valid. The first grant goes to port 0 when every request input is valid.
- R2: The request output carries the valid, data and last of the granted input. Its ID field equals the index of that input.
- R3: At most one request input sees ready high: the granted one. Its ready equals the request output's ready.
- R4: When a packet ends (a beat with last high is accepted), the next grant goes to the first valid port after the one that finished, counting upward and wrapping past `NPORT-1` to 0. Ports that are not valid are skipped.
- R5: Once a beat is offered, the grant stays fixed until a beat with last high is accepted. Beats from different ports never interleave. A stalled beat keeps its ID and data.
- R6: On the response path, only the output whose index equals the destination field is valid. That output carries the input's data and last.
- R7: The response input's ready equals the ready of the output selected by the destination field.
- R8: A response beat whose destination is `NPORT` or higher is dropped. Its ready is held high and no output is valid.
- R9: The two paths are independent. A stalled request path does not hold back a response beat, and a response beat does not hold back a request beat.
- R10: Neither path adds latency. A beat appears at the output in the same cycle that its input becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in_valid | input | NPORT | Request inputs: valid per port |
| req_in_ready | output | NPORT | Request inputs: ready per port |
| req_in_data | input | NPORT*DW | Request inputs: data, port p in bits [p*DW +: DW] |
| req_in_last | input | NPORT | Request inputs: end of packet per port |
| req_out_valid | output | 1 | Merged request output: valid |
| req_out_ready | input | 1 | Merged request output: ready |
| req_out_data | output | DW | Merged request output: data |
| req_out_last | output | 1 | Merged request output: end of packet |
| req_out_id | output | IDW | Merged request output: index of the source port |
| rsp_in_valid | input | 1 | Response input: valid |
| rsp_in_ready | output | 1 | Response input: ready |
| rsp_in_data | input | DW | Response input: data |
| rsp_in_last | input | 1 | Response input: end of packet |
| rsp_in_dest | input | IDW | Response input: destination port index |
| rsp_out_valid | output | NPORT | Response outputs: valid per port |
| rsp_out_ready | input | NPORT | Response outputs: ready per port |
| rsp_out_data | output | NPORT*DW | Response outputs: data, port p in bits [p*DW +: DW] |
| rsp_out_last | output | NPORT | Response outputs: end of packet per port |

## Verification
The assertions check the following on every cycle:
- at most one request input is ready, and at most one response output is valid;
- the ID of the request output points to a valid input;
- a stalled request beat keeps its ID and data, and the source cannot change in the middle of a packet;
- response ready follows the selected output, and a beat aimed at a missing port is dropped.

Only the directed scenarios can show the rest:
- the actual round-robin order, including skipping ports that are not valid;
- which port gets the first grant after reset;
- the data copied on each lane;
- that the two paths make progress at the same time while one of them is stalled.

// File: rtl/xs_pkg.sv
`timescale 1ns/1ps
package xs_pkg;

    // Port indices never exceed 3 bits (NPORT is limited to 8).
    typedef logic [2:0] xs_idx_t;

    typedef struct packed {
        logic    busy;   // a source owns the output
        xs_idx_t owner;  // that source
        xs_idx_t ptr;    // first candidate of the next round
    } xs_arb_t;

    function automatic xs_idx_t xs_next(input xs_idx_t cur, input int n);
        int v;
        v = int'(cur) + 1;
        if (v >= n) v = 0;
        return xs_idx_t'(v);
    endfunction

endpackage

// File: rtl/xs_rr_pick.sv
`timescale 1ns/1ps
module xs_rr_pick
    import xs_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic [NPORT-1:0] req,
    input  xs_idx_t          base,
    output logic             any,
    output xs_idx_t          pick
);
    int idx;

    always_comb begin
        pick = base;
        idx  = 0;
        // Walk from the farthest candidate back to the base, so the
        // nearest valid request at or after the base wins.
        for (int k = NPORT - 1; k >= 0; k--) begin
            idx = int'(base) + k;
            if (idx >= NPORT) idx = idx - NPORT;
            if (req[idx]) pick = xs_idx_t'(idx);
        end
        any = |req;
    end

endmodule

// File: rtl/xs_up_merge.sv
`timescale 1ns/1ps
module xs_up_merge
    import xs_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 32,
    parameter int IDW   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    in_valid,
    output logic [NPORT-1:0]    in_ready,
    input  logic [NPORT*DW-1:0] in_data,
    input  logic [NPORT-1:0]    in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DW-1:0]       out_data,
    output logic                out_last,
    output logic [IDW-1:0]      out_id
);
    xs_arb_t st_q, st_d;
    xs_idx_t pick, sel;
    logic    any_req;
    logic    hs;

    xs_rr_pick #(.NPORT(NPORT)) u_pick (
        .req  (in_valid),
        .base (st_q.ptr),
        .any  (any_req),
        .pick (pick)
    );

    always_comb begin
        sel       = st_q.busy ? st_q.owner : pick;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        in_ready  = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (sel == xs_idx_t'(p)) begin
                out_valid   = in_valid[p];
                out_data    = in_data[p*DW +: DW];
                out_last    = in_last[p];
                in_ready[p] = out_ready;
            end
        end
        out_id = sel[IDW-1:0];
        hs     = out_valid & out_ready;

        st_d = st_q;
        if (out_valid && any_req) begin
            st_d.busy  = !(hs && out_last);
            st_d.owner = sel;
        end
        if (hs && out_last) st_d.ptr = xs_next(sel, NPORT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/xs_down_route.sv
`timescale 1ns/1ps
module xs_down_route #(
    parameter int NPORT = 4,
    parameter int DW    = 32,
    parameter int IDW   = 2
) (
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DW-1:0]       in_data,
    input  logic                in_last,
    input  logic [IDW-1:0]      in_dest,
    output logic [NPORT-1:0]    out_valid,
    input  logic [NPORT-1:0]    out_ready,
    output logic [NPORT*DW-1:0] out_data,
    output logic [NPORT-1:0]    out_last
);
    always_comb begin
        in_ready  = 1'b1;   // unmatched destination: beat is consumed
        out_valid = '0;
        for (int p = 0; p < NPORT; p++) begin
            out_data[p*DW +: DW] = in_data;
            out_last[p]          = in_last;
            if (in_dest == IDW'(p)) begin
                out_valid[p] = in_valid;
                in_ready     = out_ready[p];
            end
        end
    end

endmodule

// File: rtl/xlat_stream_switch.sv
`timescale 1ns/1ps
module xlat_stream_switch #(
    parameter  int NPORT = 4,
    parameter  int DW    = 32,
    localparam int IDW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    req_in_valid,
    output logic [NPORT-1:0]    req_in_ready,
    input  logic [NPORT*DW-1:0] req_in_data,
    input  logic [NPORT-1:0]    req_in_last,
    output logic                req_out_valid,
    input  logic                req_out_ready,
    output logic [DW-1:0]       req_out_data,
    output logic                req_out_last,
    output logic [IDW-1:0]      req_out_id,
    input  logic                rsp_in_valid,
    output logic                rsp_in_ready,
    input  logic [DW-1:0]       rsp_in_data,
    input  logic                rsp_in_last,
    input  logic [IDW-1:0]      rsp_in_dest,
    output logic [NPORT-1:0]    rsp_out_valid,
    input  logic [NPORT-1:0]    rsp_out_ready,
    output logic [NPORT*DW-1:0] rsp_out_data,
    output logic [NPORT-1:0]    rsp_out_last
);
    xs_up_merge #(.NPORT(NPORT), .DW(DW), .IDW(IDW)) u_up (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_in_valid),
        .in_ready  (req_in_ready),
        .in_data   (req_in_data),
        .in_last   (req_in_last),
        .out_valid (req_out_valid),
        .out_ready (req_out_ready),
        .out_data  (req_out_data),
        .out_last  (req_out_last),
        .out_id    (req_out_id)
    );

    xs_down_route #(.NPORT(NPORT), .DW(DW), .IDW(IDW)) u_down (
        .in_valid  (rsp_in_valid),
        .in_ready  (rsp_in_ready),
        .in_data   (rsp_in_data),
        .in_last   (rsp_in_last),
        .in_dest   (rsp_in_dest),
        .out_valid (rsp_out_valid),
        .out_ready (rsp_out_ready),
        .out_data  (rsp_out_data),
        .out_last  (rsp_out_last)
    );

endmodule

// File: rtl/xlat_stream_switch_chk.sv
`timescale 1ns/1ps
module xlat_stream_switch_chk #(
    parameter int NPORT = 4,
    parameter int DW    = 32,
    parameter int IDW   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NPORT-1:0]   req_in_valid,
    input logic [NPORT-1:0]   req_in_ready,
    input logic               req_out_valid,
    input logic               req_out_ready,
    input logic [DW-1:0]      req_out_data,
    input logic               req_out_last,
    input logic [IDW-1:0]     req_out_id,
    input logic               rsp_in_valid,
    input logic               rsp_in_ready,
    input logic [IDW-1:0]     rsp_in_dest,
    input logic [NPORT-1:0]   rsp_out_valid,
    input logic [NPORT-1:0]   rsp_out_ready
);
    localparam logic [NPORT-1:0] ONE = NPORT'(1);

    a_r3_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_in_ready));

    a_r2_id_is_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
        req_out_valid |-> ((req_in_valid >> req_out_id) & ONE) != '0);

    a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out_valid && !req_out_ready) |=>
            (req_out_valid && $stable(req_out_id) && $stable(req_out_data)));

    a_r5_no_interleave: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out_valid && req_out_ready && !req_out_last) |=>
            (!req_out_valid || req_out_id == $past(req_out_id)));

    a_r6_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_out_valid));

    a_r7_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_in_valid && int'(rsp_in_dest) < NPORT) |->
            (rsp_in_ready == (((rsp_out_ready >> rsp_in_dest) & ONE) != '0)));

    a_r8_drop_far_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_in_valid && int'(rsp_in_dest) >= NPORT) |->
            (rsp_in_ready && rsp_out_valid == '0));

endmodule

bind xlat_stream_switch xlat_stream_switch_chk #(.NPORT(NPORT), .DW(DW), .IDW(IDW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_in_valid  (req_in_valid),
    .req_in_ready  (req_in_ready),
    .req_out_valid (req_out_valid),
    .req_out_ready (req_out_ready),
    .req_out_data  (req_out_data),
    .req_out_last  (req_out_last),
    .req_out_id    (req_out_id),
    .rsp_in_valid  (rsp_in_valid),
    .rsp_in_ready  (rsp_in_ready),
    .rsp_in_dest   (rsp_in_dest),
    .rsp_out_valid (rsp_out_valid),
    .rsp_out_ready (rsp_out_ready)
);

// File: tb/xlat_stream_switch_test.sv
`timescale 1ns/1ps
module xlat_stream_switch_test;
    localparam int N   = 3;
    localparam int DW  = 16;
    localparam int IDW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_v = '0, req_l = '0, req_r;
    logic [N*DW-1:0]   req_d = '0;
    logic              up_v, up_r = 1'b0, up_l;
    logic [DW-1:0]     up_d;
    logic [IDW-1:0]    up_id;
    logic              rsp_v = 1'b0, rsp_l = 1'b0, rsp_r;
    logic [DW-1:0]     rsp_d = '0;
    logic [IDW-1:0]    rsp_dest = '0;
    logic [N-1:0]      dn_v, dn_r = '0, dn_l;
    logic [N*DW-1:0]   dn_d;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xlat_stream_switch #(.NPORT(N), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_in_valid(req_v), .req_in_ready(req_r), .req_in_data(req_d), .req_in_last(req_l),
        .req_out_valid(up_v), .req_out_ready(up_r), .req_out_data(up_d),
        .req_out_last(up_l), .req_out_id(up_id),
        .rsp_in_valid(rsp_v), .rsp_in_ready(rsp_r), .rsp_in_data(rsp_d),
        .rsp_in_last(rsp_l), .rsp_in_dest(rsp_dest),
        .rsp_out_valid(dn_v), .rsp_out_ready(dn_r), .rsp_out_data(dn_d), .rsp_out_last(dn_l)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input int p, input logic v, input logic l, input logic [DW-1:0] d);
        req_v[p] = v;
        req_l[p] = l;
        req_d[p*DW +: DW] = d;
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 req out idle", 64'(up_v), 64'd0);
        chk("R1 rsp out idle", 64'(dn_v), 64'd0);
    endtask

    // All ports offer single-beat packets; expect 0,1,2 in turn.
    task automatic t_round_robin();
        @(negedge clk);
        up_r = 1'b1;
        for (int p = 0; p < N; p++) put(p, 1'b1, 1'b1, DW'(16'h1000 + p));
        for (int k = 0; k < N; k++) begin
            #1;
            chk("R4 rr order id", 64'(up_id), 64'(k));
            chk("R2 data of granted", 64'(up_d), 64'(16'h1000 + k));
            chk("R3 ready one-hot", 64'(req_r), 64'(1 << k));
            @(negedge clk);
        end
        req_v = '0;
    endtask

    // Port 0 sends three beats with a stall; port 1 waits.
    task automatic t_packet_lock();
        @(negedge clk);
        put(0, 1'b1, 1'b0, 16'h2000);
        put(1, 1'b1, 1'b1, 16'h2100);
        #1; chk("R5 first beat id", 64'(up_id), 64'd0);
        @(negedge clk);
        put(0, 1'b1, 1'b0, 16'h2001); up_r = 1'b0;
        #1;
        chk("R5 stalled id", 64'(up_id), 64'd0);
        chk("R5 stalled valid", 64'(up_v), 64'd1);
        chk("R3 no ready in stall", 64'(req_r), 64'd0);
        @(negedge clk);
        up_r = 1'b1;
        #1; chk("R5 resumed data", 64'(up_d), 64'h2001);
        @(negedge clk);
        put(0, 1'b1, 1'b1, 16'h2002);
        #1;
        chk("R5 last beat id", 64'(up_id), 64'd0);
        chk("R2 last flag", 64'(up_l), 64'd1);
        @(negedge clk);
        put(0, 1'b0, 1'b0, 16'h0);
        #1;
        chk("R5 next owner", 64'(up_id), 64'd1);
        chk("R2 next data", 64'(up_d), 64'h2100);
        @(negedge clk);
        req_v = '0;
    endtask

    // Pointer now at 2; only port 1 valid: skipped port, no latency.
    task automatic t_skip_latency();
        @(negedge clk);
        put(1, 1'b1, 1'b1, 16'h2200);
        #1;
        chk("R10 same-cycle valid", 64'(up_v), 64'd1);
        chk("R4 skip idle port", 64'(up_id), 64'd1);
        @(negedge clk);
        req_v = '0;
    endtask

    task automatic t_route();
        for (int d = 0; d < N; d++) begin
            @(negedge clk);
            rsp_v = 1'b1; rsp_dest = IDW'(d); rsp_d = DW'(16'h3000 + d);
            rsp_l = (d == 2); dn_r = 3'b010;
            #1;
            chk("R6 dest valid", 64'(dn_v), 64'(1 << d));
            chk("R6 dest data", 64'(dn_d[d*DW +: DW]), 64'(16'h3000 + d));
            chk("R6 dest last", 64'(dn_l[d]), 64'(d == 2));
            chk("R7 ready follows", 64'(rsp_r), 64'(d == 1));
        end
        @(negedge clk);
        rsp_dest = 2'd3; dn_r = '0;
        #1;
        chk("R8 drop ready", 64'(rsp_r), 64'd1);
        chk("R8 drop no valid", 64'(dn_v), 64'd0);
        @(negedge clk);
        rsp_v = 1'b0;
    endtask

    task automatic t_independent();
        @(negedge clk);
        put(0, 1'b1, 1'b1, 16'h4000); up_r = 1'b0;
        rsp_v = 1'b1; rsp_dest = 2'd2; rsp_d = 16'h4100; dn_r = 3'b100;
        #1;
        chk("R9 rsp passes", 64'(rsp_r), 64'd1);
        chk("R9 rsp valid", 64'(dn_v), 64'b100);
        chk("R9 req stalled", 64'(req_r), 64'd0);
        chk("R9 req offered", 64'(up_v), 64'd1);
        @(negedge clk);
        up_r = 1'b1; dn_r = 3'b000;
        #1;
        chk("R9 req passes", 64'(req_r), 64'b001);
        chk("R9 rsp held", 64'(rsp_r), 64'd0);
        @(negedge clk);
        req_v = '0; rsp_v = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_round_robin();
        t_packet_lock();
        t_skip_latency();
        t_route();
        t_independent();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule